// File: doc/BRIEF.md
# Bus Operation Queue

This block sits between a fast host and a slower external 16-bit bus. The host posts byte or word reads and writes, each with a 24-bit address and, for writes, a data word. Up to seven of these can wait at once. The block runs them on the external bus strictly in the order they arrived. Each accepted command takes the next 3-bit sequence number. The block always shows, in Gray code, the number of the oldest command that has not finished. The host can therefore count completions by watching one output, in the manner of a sliding window.

Each completed command leaves a result slot, indexed by its sequence number. The slot holds a done flag, a success flag and the data the bus returned. The host reads a slot by putting a sequence number on the status select input. While no command is waiting, the block fills the bus with word reads of one fixed safe address, so the bus never goes quiet. These filler reads leave no trace in the results.

The external bus is a plain request/acknowledge port. The block holds a request with steady fields until the bus answers with either an acknowledge or an error pulse.

Top module: `bus_op_queue`

## Requirements
- R1: At most 7 commands are outstanding (accepted and not yet finished on the bus). `cmd_ready` is low exactly while 7 are outstanding, and a command offered then is not accepted.
- R2: `cmd_seq` gives the number the next accepted command will receive. It is 0 after reset, advances by one on each acceptance, wraps from 7 to 0, and does not change otherwise.
- R3: `busy_gray` is the Gray code (b xor b>>1) of the number of the oldest unfinished command, which is one after the most recently finished one. It is 0 after reset, moves only on a clock edge, and changes by exactly one bit per finished command.
- R4: Commands run on the bus in acceptance order. While `bus_req` is high, `bus_write` is 1 for writes, `bus_word` is 1 for word and 0 for byte, `bus_addr` and `bus_wdata` carry the command's fields, and all of them hold until `bus_ack` or `bus_err` is seen.
- R5: When a command finishes, its slot reports `stat_done`=1, `stat_ok`=1 on acknowledge, and `stat_rdata` equal to `bus_rdata` in the finishing cycle. The slot is chosen by `stat_seq`, read combinationally. After reset every slot reports `stat_done`=0.
- R6: From the second clock after reset release, `bus_req` stays high in every cycle. Whenever no command is waiting, the block starts a filler word read (`bus_write`=0, `bus_word`=1, `bus_wdata`=0) of address `SAFE_ADDR`.
- R7: A filler read that has started always runs until the bus answers, even if a command arrives meanwhile. Filler reads write no result slot and do not move `busy_gray`. A real command starts in the cycle after the bus answers, and only if it was accepted before that cycle.
- R8: A `bus_err` answer finishes the current command with `stat_done`=1 and `stat_ok`=0. The next command starts at once.
- R9: A slot keeps its result until a new command is accepted with the same sequence number. From the cycle after that acceptance, the slot reports `stat_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | A command can be accepted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| cmd_addr | input | 24 | Command address |
| cmd_wdata | input | 16 | Write data |
| cmd_seq | output | 3 | Sequence number for the next accepted command |
| busy_gray | output | 3 | Gray-coded number of the oldest unfinished command |
| stat_seq | input | 3 | Result slot select |
| stat_done | output | 1 | Selected slot holds a finished result |
| stat_ok | output | 1 | Selected command ended with acknowledge |
| stat_rdata | output | 16 | Data captured when the selected command finished |
| bus_req | output | 1 | Bus operation in progress |
| bus_write | output | 1 | Current operation is a write |
| bus_word | output | 1 | Current operation is a word access |
| bus_addr | output | 24 | Current operation address |
| bus_wdata | output | 16 | Current write data |
| bus_ack | input | 1 | Bus completes the operation successfully |
| bus_err | input | 1 | Bus completes the operation with an error |
| bus_rdata | input | 16 | Read data, valid with bus_ack or bus_err |

## Verification
The interesting overlaps are an enqueue that lands in the same cycle as a bus completion, and a command that arrives while a filler read is still running. The bench provokes the first with back-to-back offers against a bus that answers in zero to two wait cycles. The occupancy must then stay the same and the launch choice must ignore the same-cycle arrival. The second is provoked by offering commands after idle stretches. The reference model, stepped on every clock, predicts the bus fields, the Gray output and every result slot. A filler read that gets cut short, or a command started too early, shows up as a field mismatch in that cycle.

// File: rtl/bopq_pkg.sv
package bopq_pkg;
  localparam int SEQ_W    = 3;
  localparam int ADDR_W   = 24;
  localparam int DATA_W   = 16;
  localparam int SLOTS    = 1 << SEQ_W;
  localparam int MAX_PEND = SLOTS - 1;

  typedef logic [SEQ_W-1:0] seq_t;

  typedef struct packed {
    logic              wr;
    logic              word;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_cmd_t;

  localparam seq_t SEQ_ONE = seq_t'(1);

  function automatic seq_t to_gray(seq_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic seq_t from_gray(seq_t g);
    seq_t b;
    b[SEQ_W-1] = g[SEQ_W-1];
    for (int i = SEQ_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/bopq_cmd_store.sv
module bopq_cmd_store
  import bopq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  bus_cmd_t push_cmd,
  input  logic     pop,
  output seq_t     wr_seq,
  output seq_t     rd_seq,
  output seq_t     rd_gray,
  output seq_t     pend_cnt,
  output bus_cmd_t head,
  output bus_cmd_t head_nxt
);
  bus_cmd_t mem [SLOTS];
  seq_t     wr_q, wr_d;
  seq_t     rdg_q, rdg_d;
  seq_t     cnt_q, cnt_d;
  seq_t     rd_bin;

  assign rd_bin = from_gray(rdg_q);

  always_comb begin
    wr_d  = wr_q;
    rdg_d = rdg_q;
    cnt_d = cnt_q;
    if (push) wr_d = wr_q + SEQ_ONE;
    if (pop)  rdg_d = to_gray(rd_bin + SEQ_ONE);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + SEQ_ONE;
      2'b01:   cnt_d = cnt_q - SEQ_ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rdg_q <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rdg_q <= rdg_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (wr_q == seq_t'(s));
    always_ff @(posedge clk) begin
      if (slot_we) mem[s] <= push_cmd;
    end
  end

  assign wr_seq   = wr_q;
  assign rd_seq   = rd_bin;
  assign rd_gray  = rdg_q;
  assign pend_cnt = cnt_q;
  assign head     = mem[rd_bin];
  assign head_nxt = mem[rd_bin + SEQ_ONE];
endmodule

// File: rtl/bopq_bus_engine.sv
module bopq_bus_engine
  import bopq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SAFE_ADDR = 24'h400000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  seq_t     pend_cnt,
  input  bus_cmd_t head,
  input  bus_cmd_t head_nxt,
  input  logic     bus_ack,
  input  logic     bus_err,
  output logic     bus_req,
  output bus_cmd_t cur,
  output logic     is_dummy,
  output logic     real_done
);
  logic     act_q, act_d;
  logic     dum_q, dum_d;
  bus_cmd_t cur_q, cur_d;
  logic     fin, launch;
  seq_t     avail;
  bus_cmd_t filler;

  assign filler    = '{wr: 1'b0, word: 1'b1, addr: SAFE_ADDR, data: '0};
  assign fin       = act_q && (bus_ack || bus_err);
  assign real_done = fin && !dum_q;
  assign launch    = !act_q || fin;
  assign avail     = pend_cnt - seq_t'(real_done);

  always_comb begin
    act_d = act_q;
    dum_d = dum_q;
    cur_d = cur_q;
    if (launch) begin
      act_d = 1'b1;
      if (avail != '0) begin
        dum_d = 1'b0;
        cur_d = real_done ? head_nxt : head;
      end else begin
        dum_d = 1'b1;
        cur_d = filler;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      dum_q <= 1'b0;
      cur_q <= '0;
    end else begin
      act_q <= act_d;
      dum_q <= dum_d;
      cur_q <= cur_d;
    end
  end

  assign bus_req  = act_q;
  assign cur      = cur_q;
  assign is_dummy = dum_q;
endmodule

// File: rtl/bopq_result_store.sv
module bopq_result_store
  import bopq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  seq_t              clr_seq,
  input  logic              wr_en,
  input  seq_t              wr_seq,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wr_data,
  input  seq_t              rd_seq,
  output logic              rd_done,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_data
);
  logic              done_q [SLOTS];
  logic              ok_q   [SLOTS];
  logic [DATA_W-1:0] data_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_res
    logic set_en, clr_en;
    logic done_d, ok_d;
    logic [DATA_W-1:0] data_d;

    assign set_en = wr_en && (wr_seq == seq_t'(s));
    assign clr_en = clr && (clr_seq == seq_t'(s));

    always_comb begin
      done_d = done_q[s];
      ok_d   = ok_q[s];
      data_d = data_q[s];
      if (set_en) begin
        done_d = 1'b1;
        ok_d   = wr_ok;
        data_d = wr_data;
      end else if (clr_en) begin
        done_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        done_q[s] <= 1'b0;
        ok_q[s]   <= 1'b0;
        data_q[s] <= '0;
      end else begin
        done_q[s] <= done_d;
        ok_q[s]   <= ok_d;
        data_q[s] <= data_d;
      end
    end
  end

  assign rd_done = done_q[rd_seq];
  assign rd_ok   = ok_q[rd_seq];
  assign rd_data = data_q[rd_seq];
endmodule

// File: rtl/bus_op_queue.sv
module bus_op_queue
  import bopq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SAFE_ADDR = 24'h400000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_word,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [SEQ_W-1:0]  cmd_seq,
  output logic [SEQ_W-1:0]  busy_gray,
  input  logic [SEQ_W-1:0]  stat_seq,
  output logic              stat_done,
  output logic              stat_ok,
  output logic [DATA_W-1:0] stat_rdata,
  output logic              bus_req,
  output logic              bus_write,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic [1:0] rsync_q;
  logic       rst_core_n;
  logic       accept;
  bus_cmd_t   push_cmd, head, head_nxt, cur;
  seq_t       wr_seq, rd_seq, rd_gray, pend_cnt;
  logic       eng_dummy, real_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign cmd_ready = (pend_cnt != seq_t'(MAX_PEND));
  assign accept    = cmd_valid && cmd_ready;
  assign push_cmd  = '{wr: cmd_write, word: cmd_word, addr: cmd_addr, data: cmd_wdata};

  bopq_cmd_store u_store (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push     (accept),
    .push_cmd (push_cmd),
    .pop      (real_done),
    .wr_seq   (wr_seq),
    .rd_seq   (rd_seq),
    .rd_gray  (rd_gray),
    .pend_cnt (pend_cnt),
    .head     (head),
    .head_nxt (head_nxt)
  );

  bopq_bus_engine #(.SAFE_ADDR(SAFE_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pend_cnt  (pend_cnt),
    .head      (head),
    .head_nxt  (head_nxt),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_req   (bus_req),
    .cur       (cur),
    .is_dummy  (eng_dummy),
    .real_done (real_done)
  );

  bopq_result_store u_results (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (accept),
    .clr_seq (wr_seq),
    .wr_en   (real_done),
    .wr_seq  (rd_seq),
    .wr_ok   (!bus_err),
    .wr_data (bus_rdata),
    .rd_seq  (stat_seq),
    .rd_done (stat_done),
    .rd_ok   (stat_ok),
    .rd_data (stat_rdata)
  );

  assign cmd_seq   = wr_seq;
  assign busy_gray = rd_gray;
  assign bus_write = cur.wr;
  assign bus_word  = cur.word;
  assign bus_addr  = cur.addr;
  assign bus_wdata = cur.data;
endmodule

// File: rtl/bopq_checker.sv
module bopq_checker
  import bopq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SAFE_ADDR = 24'h400000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [SEQ_W-1:0]  cmd_seq,
  input logic [SEQ_W-1:0]  busy_gray,
  input logic [SEQ_W-1:0]  pend_cnt,
  input logic              bus_req,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              is_dummy
);
  AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == seq_t'(MAX_PEND)) |-> !cmd_ready); // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (cmd_seq == seq_t'($past(cmd_seq) + SEQ_ONE))); // R2

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> $stable(cmd_seq)); // R2

  AST_GRAY_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> ($countones(busy_gray ^ $past(busy_gray)) <= 1)); // R3

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=> ($stable(bus_addr) && $stable(bus_write))); // R4

  AST_BUS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_req); // R6

  AST_FILLER_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && is_dummy) |-> (bus_addr == SAFE_ADDR && !bus_write)); // R6

  AST_FILLER_RUNS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && is_dummy && !bus_ack && !bus_err) |=> is_dummy); // R7

  AST_FILLER_NO_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && is_dummy) |=> $stable(busy_gray)); // R7
endmodule

bind bus_op_queue bopq_checker #(.SAFE_ADDR(SAFE_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_seq   (cmd_seq),
  .busy_gray (busy_gray),
  .pend_cnt  (pend_cnt),
  .bus_req   (bus_req),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_ack   (bus_ack),
  .bus_err   (bus_err),
  .is_dummy  (eng_dummy)
);

// File: tb/tb_bus_op_queue.sv
module tb_bus_op_queue;
  localparam int SAFE = 24'h400000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_write, cmd_word;
  logic [23:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic        cmd_ready;
  logic [2:0]  cmd_seq, busy_gray, stat_seq;
  logic        stat_done, stat_ok;
  logic [15:0] stat_rdata;
  logic        bus_req, bus_write, bus_word;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ack, bus_err;
  logic [15:0] bus_rdata;

  always #4 clk = ~clk;

  bus_op_queue dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_word(cmd_word), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_seq(cmd_seq), .busy_gray(busy_gray),
    .stat_seq(stat_seq), .stat_done(stat_done), .stat_ok(stat_ok), .stat_rdata(stat_rdata),
    .bus_req(bus_req), .bus_write(bus_write), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  typedef struct { bit wr; bit word; int addr; int data; } mcmd_t;

  mcmd_t mq[$];
  mcmd_t m_cur;
  int    n_chk = 0, n_fail = 0;
  bit    rs1, rs2;
  bit    m_active, m_dummy, m_newop;
  int    m_wr, m_rd;
  bit    m_done[8], m_ok[8], m_reuse[8];
  int    m_rdat[8];
  int    lat, opn;
  bit    slow;
  bit    finished = 0;

  task automatic chk(string r, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic model_core_reset();
    mq.delete();
    m_active = 0; m_dummy = 0; m_newop = 0;
    m_wr = 0; m_rd = 0;
    for (int i = 0; i < 8; i++) begin
      m_done[i] = 0; m_ok[i] = 0; m_reuse[i] = 0; m_rdat[i] = 0;
    end
  endtask

  task automatic model_update();
    int  cnt0;
    bit  acc, fin, rdone;
    m_newop = 0;
    if (!rst_n) begin
      rs1 = 0; rs2 = 0;
      model_core_reset();
      return;
    end
    if (!rs2) begin
      model_core_reset();
    end else begin
      cnt0  = mq.size();
      acc   = cmd_valid && (cnt0 < 7);
      fin   = m_active && (bus_ack || bus_err);
      rdone = fin && !m_dummy;
      if (rdone) begin
        m_done[m_rd] = 1;
        m_ok[m_rd]   = !bus_err;
        m_rdat[m_rd] = int'(bus_rdata);
        m_reuse[m_rd] = 0;
        void'(mq.pop_front());
        m_rd = (m_rd + 1) % 8;
      end
      if (!m_active || fin) begin
        m_active = 1;
        m_newop  = 1;
        if (cnt0 - int'(rdone) > 0) begin
          m_dummy = 0;
          m_cur   = mq[0];
        end else begin
          m_dummy = 1;
        end
      end
      if (acc) begin
        mcmd_t c;
        c.wr = cmd_write; c.word = cmd_word;
        c.addr = int'(cmd_addr); c.data = int'(cmd_wdata);
        mq.push_back(c);
        m_done[m_wr] = 0;
        m_reuse[m_wr] = 1;
        m_wr = (m_wr + 1) % 8;
      end
    end
    rs2 = rs1;
    rs1 = 1;
  endtask

  task automatic compare();
    string tb;
    int    s;
    chk("R1", int'(cmd_ready), int'(mq.size() < 7), "cmd_ready");
    chk("R2", int'(cmd_seq), m_wr, "cmd_seq");
    chk("R3", int'(busy_gray), m_rd ^ (m_rd >> 1), "busy_gray");
    if (m_dummy) tb = (mq.size() > 0) ? "R7" : "R6";
    else         tb = "R4";
    chk(tb, int'(bus_req), int'(m_active), "bus_req");
    if (m_active) begin
      chk(tb, int'(bus_addr),  m_dummy ? SAFE : m_cur.addr, "bus_addr");
      chk(tb, int'(bus_write), m_dummy ? 0 : int'(m_cur.wr), "bus_write");
      chk(tb, int'(bus_word),  m_dummy ? 1 : int'(m_cur.word), "bus_word");
      chk(tb, int'(bus_wdata), m_dummy ? 0 : m_cur.data, "bus_wdata");
    end
    s = int'(stat_seq);
    chk((m_reuse[s] && !m_done[s]) ? "R9" : "R5", int'(stat_done), int'(m_done[s]), "stat_done");
    if (m_done[s]) begin
      chk(m_ok[s] ? "R5" : "R8", int'(stat_ok), int'(m_ok[s]), "stat_ok");
      chk("R5", int'(stat_rdata), m_rdat[s], "stat_rdata");
    end
  endtask

  task automatic drive_bus();
    bit fire, bad;
    if (m_active) begin
      if (m_newop) begin
        lat = slow ? 6 : (opn % 3);
        opn++;
      end else if (lat > 0) begin
        lat--;
      end
    end
    fire = m_active && (lat == 0);
    bad  = fire && !m_dummy && m_cur.addr[23];
    bus_ack   = fire && !bad;
    bus_err   = bad;
    bus_rdata = m_dummy ? 16'h0F0F : (16'(m_cur.addr) ^ 16'h5A3C);
  endtask

  task automatic step();
    @(negedge clk);
    model_update();
    compare();
    drive_bus();
  endtask

  task automatic push(bit w, bit wd, int a, int d);
    cmd_valid = 1; cmd_write = w; cmd_word = wd;
    cmd_addr = 24'(a); cmd_wdata = 16'(d);
    step();
    cmd_valid = 0;
  endtask

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_word = 0;
    cmd_addr = 0; cmd_wdata = 0; stat_seq = 0;
    bus_ack = 0; bus_err = 0; bus_rdata = 0;
    lat = 0; opn = 0; slow = 0; rs1 = 0; rs2 = 0;
    model_core_reset();
    // reset state: R2 seq 0, R3 gray 0, R5 no done slots
    repeat (4) step();
    rst_n = 1;
    // idle: filler reads keep the bus busy (R6)
    repeat (12) step();
    // in-order execution with mixed sizes and quick answers (R4, R5)
    for (int i = 0; i < 20; i++) begin
      stat_seq = 3'(i);
      push(i % 2 == 1, i % 3 != 0, i * 24'h102, i * 16'h1111);
      if (i % 4 == 3) repeat (3) step();
    end
    repeat (10) step();
    // slow bus, back-to-back offers: queue fills to 7 (R1), wraps (R2)
    slow = 1;
    for (int i = 0; i < 12; i++) begin
      stat_seq = 3'(i + 3);
      push(i % 2 == 0, 1, 24'h001000 + i * 2, 16'hA000 + i);
    end
    repeat (90) step();
    slow = 0;
    // error answers mixed with good ones (R8)
    for (int i = 0; i < 10; i++) begin
      stat_seq = 3'(i);
      push(i % 3 == 0, i % 2 == 0, (i % 2 == 0) ? (24'h800020 + i) : (24'h000300 + i), 16'h0BAD + i);
    end
    repeat (10) step();
    // status sweep after quiet (R5, R8)
    for (int s = 0; s < 8; s++) begin
      stat_seq = 3'(s);
      step();
    end
    // offers arriving during filler reads and completions (R7, R9)
    for (int i = 0; i < 60; i++) begin
      stat_seq = 3'(i * 3);
      if (i % 5 == 4) step();
      else push(i % 4 == 1, i % 2 == 1, (i % 7 == 0) ? 24'h8000F0 : (24'h002000 + i), i * 16'h0107);
    end
    repeat (20) step();
    for (int s = 0; s < 8; s++) begin
      stat_seq = 3'(s);
      step();
    end
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule